// File: doc/BRIEF.md
# Multi-Wavefront Issue Arbiter

This block chooses, every clock cycle, which of a set of independent instruction streams (wavefronts) issue their head instruction. Each wavefront offers at most one instruction, marked with a valid bit, a blocked bit and a 2-bit class. The arbiter fills a separate slot budget for each instruction class, subject to an overall cap on issues per cycle. It never picks the same wavefront twice in a cycle. Order inside a stream is therefore kept: a stream issues one instruction at a time, and the next one is only presented after the grant.

Within each class, a rotating pointer decides which wavefronts win. Scanning starts at the pointer and wraps around. After a grant, the pointer moves to one past the last wavefront granted in that class. When a class budget is full, the remaining eligible wavefronts of that class are passed over for this cycle. They stay first in line for the next cycle. Grants and per-class grant counts are registered, so they appear one cycle after the request.

Top module: `wave_issue_arb`

## Requirements
- R1: Each wavefront presents a 2-bit class in its slice `req_class[2*i+1:2*i]`: 00 vector ALU, 01 scalar, 10 vector memory, 11 control. A wavefront is eligible only when `req_valid[i]` is 1 and `req_blocked[i]` is 0.
- R2: `grant_o[i]` is set only for a wavefront that was eligible in the cycle before. A blocked or idle wavefront is never granted.
- R3: A wavefront receives at most one grant per cycle. Each count output equals the number of granted wavefronts of its class.
- R4: The total number of grants per cycle never exceeds `ISSUE_MAX` (default 7). When this cap binds, the class budgets are filled in this order: vector ALU, scalar, vector memory, control.
- R5: Per cycle, at most `ALU_MAX` (2) vector ALU grants are made, `SALU_MAX` (2) scalar, `VMEM_MAX` (1) vector memory and `CTRL_MAX` (2) control. Eligible wavefronts beyond a full budget are not granted.
- R6: Within a class, the candidates are taken in ascending wavefront index, starting at that class's pointer and wrapping from the highest index to 0. After a cycle with grants, the pointer becomes one past the last granted wavefront. After a cycle without grants in that class, the pointer is left unchanged.
- R7: Grants and counts are registered. They reflect the inputs sampled at the previous rising edge and hold steady between edges.
- R8: A synchronous active-high reset clears all grants and counts and sets every class pointer to wavefront 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | WAVES | Head instruction present, per wavefront |
| req_blocked | input | WAVES | Wavefront blocked, per wavefront |
| req_class | input | 2*WAVES | Class of each head instruction |
| grant_o | output | WAVES | Registered issue grant, per wavefront |
| alu_count_o | output | CW | Vector ALU grants this cycle |
| salu_count_o | output | CW | Scalar grants this cycle |
| vmem_count_o | output | CW | Vector memory grants this cycle |
| ctrl_count_o | output | CW | Control grants this cycle |

## Verification
The assertions assume that the request, blocked and class inputs are stable around each rising edge. They also assume that reset is held for at least one edge before the first request. The bench drives all inputs on the falling edge and holds reset for several cycles, so both conditions hold. The class field is always a defined 2-bit value, so every valid request belongs to exactly one class. The stimulus never puts X on any input, and it keeps a wavefront's request valid until that wavefront is granted or the request is deliberately withdrawn.

// File: rtl/wave_issue_arb.sv
module wave_issue_arb #(
  parameter int WAVES     = 20,
  parameter int ALU_MAX   = 2,
  parameter int SALU_MAX  = 2,
  parameter int VMEM_MAX  = 1,
  parameter int CTRL_MAX  = 2,
  parameter int ISSUE_MAX = 7,
  localparam int PW = (WAVES > 1) ? $clog2(WAVES) : 1,
  localparam int CW = $clog2(ISSUE_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WAVES-1:0]   req_valid,
  input  logic [WAVES-1:0]   req_blocked,
  input  logic [2*WAVES-1:0] req_class,
  output logic [WAVES-1:0]   grant_o,
  output logic [CW-1:0]      alu_count_o,
  output logic [CW-1:0]      salu_count_o,
  output logic [CW-1:0]      vmem_count_o,
  output logic [CW-1:0]      ctrl_count_o
);

  function automatic int class_limit(input int c);
    case (c)
      0:       return ALU_MAX;
      1:       return SALU_MAX;
      2:       return VMEM_MAX;
      default: return CTRL_MAX;
    endcase
  endfunction

  logic [PW-1:0]    ptr_q [4];
  logic [PW-1:0]    ptr_d [4];
  logic [CW-1:0]    cnt_q [4];
  logic [CW-1:0]    cnt_d [4];
  logic [WAVES-1:0] grant_d;
  logic [WAVES-1:0] ready;

  assign ready = req_valid & ~req_blocked;

  always_comb begin
    int left, budget, taken, idx;
    grant_d = '0;
    left = ISSUE_MAX;
    for (int c = 0; c < 4; c++) begin
      budget = class_limit(c);
      if (budget > left) budget = left;
      taken = 0;
      ptr_d[c] = ptr_q[c];
      for (int k = 0; k < WAVES; k++) begin
        idx = int'(ptr_q[c]) + k;
        if (idx >= WAVES) idx = idx - WAVES;
        if (ready[idx] && req_class[2*idx +: 2] == 2'(c) && taken < budget) begin
          grant_d[idx] = 1'b1;
          taken = taken + 1;
          ptr_d[c] = (idx == WAVES - 1) ? '0 : PW'(idx + 1);
        end
      end
      cnt_d[c] = CW'(taken);
      left = left - taken;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      for (int c = 0; c < 4; c++) begin
        ptr_q[c] <= '0;
        cnt_q[c] <= '0;
      end
    end else begin
      grant_o <= grant_d;
      for (int c = 0; c < 4; c++) begin
        ptr_q[c] <= ptr_d[c];
        cnt_q[c] <= cnt_d[c];
      end
    end
  end

  assign alu_count_o  = cnt_q[0];
  assign salu_count_o = cnt_q[1];
  assign vmem_count_o = cnt_q[2];
  assign ctrl_count_o = cnt_q[3];

  // R2
  eligible_only_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o & ~$past(ready)) == '0);

  // R4
  total_cap_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_o) <= ISSUE_MAX);

  // R5
  class_cap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(alu_count_o) <= ALU_MAX && int'(salu_count_o) <= SALU_MAX &&
    int'(vmem_count_o) <= VMEM_MAX && int'(ctrl_count_o) <= CTRL_MAX);

  // R3
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    int'(alu_count_o) + int'(salu_count_o) + int'(vmem_count_o) + int'(ctrl_count_o)
      == $countones(grant_o));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grant_o == '0 && alu_count_o == '0));

endmodule

// File: tb/wave_issue_arb_tb.sv
module wave_issue_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]   v = '0, b = '0;
  logic [2*NW-1:0] c = '0;
  logic [NW-1:0]   g;
  logic [2:0]      n0, n1, n2, n3;

  logic [5:0]  sv = '0, sb = '0;
  logic [11:0] sc = '0;
  logic [5:0]  sg;
  logic [2:0]  s0, s1, s2, s3;

  int checks = 0, errors = 0;
  int mptr [4];
  int ecnt [4];
  logic [NW-1:0] prev_g = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_issue_arb dut_i (.clk(clk), .rst(rst), .req_valid(v), .req_blocked(b),
    .req_class(c), .grant_o(g), .alu_count_o(n0), .salu_count_o(n1),
    .vmem_count_o(n2), .ctrl_count_o(n3));

  wave_issue_arb #(.WAVES(6), .ISSUE_MAX(4)) dut_cap_i (.clk(clk), .rst(rst),
    .req_valid(sv), .req_blocked(sb), .req_class(sc), .grant_o(sg),
    .alu_count_o(s0), .salu_count_o(s1), .vmem_count_o(s2), .ctrl_count_o(s3));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(output logic [NW-1:0] eg);
    int left, lim, k, w, last;
    eg = '0;
    left = 7;
    for (int cl = 0; cl < 4; cl++) begin
      lim = (cl == 2) ? 1 : 2;
      if (lim > left) lim = left;
      k = 0; last = -1;
      for (int off = 0; off < NW; off++) begin
        w = (mptr[cl] + off) % NW;
        if (v[w] && !b[w] && int'(c[2*w +: 2]) == cl && k < lim) begin
          eg[w] = 1'b1; k++; last = w;
        end
      end
      if (last >= 0) mptr[cl] = (last + 1) % NW;
      ecnt[cl] = k;
      left -= k;
    end
  endtask

  task automatic step(input logic [NW-1:0] nv, input logic [NW-1:0] nb,
                      input logic [2*NW-1:0] nc, input string tag);
    logic [NW-1:0] eg;
    v = nv; b = nb; c = nc;
    #1;
    chk("R7 hold before edge", g, prev_g);
    model(eg);
    @(negedge clk);
    chk({tag, " R2 R3 R6 grant"}, g, eg);
    chk({tag, " R3 R5 alu count"}, n0, ecnt[0]);
    chk({tag, " R3 R5 scalar count"}, n1, ecnt[1]);
    chk({tag, " R3 R5 vmem count"}, n2, ecnt[2]);
    chk({tag, " R3 R5 ctrl count"}, n3, ecnt[3]);
    prev_g = eg;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2*NW-1:0] rc;
    for (int i = 0; i < 4; i++) mptr[i] = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset grant", g, 0);
    chk("R8 reset counts", {n0, n1, n2, n3}, 0);
    v = '1;
    @(negedge clk);
    chk("R8 reset holds grant with requests", g, 0);
    rst = 1'b0;
    v = '0;

    // R6 R5: all vector ALU, arithmetic rotation by two
    for (int k = 0; k < 12; k++) begin
      v = '1; b = '0; c = '0;
      #1;
      @(negedge clk);
      chk("R6 ALU rotation", g, 20'(64'h3 << (2 * (k % 10))));
      chk("R5 ALU count two", n0, 2);
      for (int i = 0; i < 4; i++) if (i == 0) mptr[0] = (2 * (k + 1)) % NW;
      prev_g = g;
    end

    // R2: first five blocked, remaining scalar
    step('1, 20'h0001F, {NW{2'b01}}, "R2 blocked");
    step(20'h00000, '0, '0, "R6 idle keeps pointer");
    // R5: every class saturated
    for (int w = 0; w < NW; w++) rc[2*w +: 2] = 2'(w % 4);
    step('1, '0, rc, "R5 all classes");
    step('1, '0, rc, "R5 all classes again");
    // R1: single vector memory requester
    step(20'h80000, '0, {2'b10, 38'h0}, "R1 single vmem");

    // random sweep
    for (int t = 0; t < 3000; t++) begin
      logic [NW-1:0] rv, rb;
      rv = NW'($urandom);
      rb = (t % 3 == 0) ? '0 : NW'($urandom & $urandom);
      for (int w = 0; w < NW; w++) rc[2*w +: 2] = 2'($urandom % 4);
      step(rv, rb, rc, "R1 R4 random");
    end

    // R4: total cap with class order on the small instance
    sv = 6'h3F; sb = '0; sc = {2'b11, 2'b10, 2'b01, 2'b01, 2'b00, 2'b00};
    @(negedge clk);
    chk("R4 cap grant", sg, 6'b001111);
    chk("R4 cap counts", {s0, s1, s2, s3}, {3'd2, 3'd2, 3'd0, 3'd0});
    sc = {2'b01, 2'b01, 2'b00, 2'b11, 2'b11, 2'b10};
    @(negedge clk);
    chk("R4 cap order grant", sg, 6'b111001);
    chk("R4 cap order counts", {s0, s1, s2, s3}, {3'd1, 3'd2, 3'd1, 3'd0});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule